// File: doc/BRIEF.md
# Vertex Input State Packet Parser

This block takes a stream of 32-bit command dwords, one per cycle, and decodes the two variable-length state packets that describe how vertices are fetched: a list of vertex buffers and a list of vertex elements. A start flag marks the header dword of each packet. The header holds a type code and a length field. The parser walks the packet body in fixed-size groups and writes the fields of each group into on-chip storage. That storage is laid out so that block RAM can hold it.

For buffer packets, each group names the buffer slot it writes. The parser records the slot's pitch and size, updates the base address only when the group asks for it, and sets the slot's bit in a valid bitmap. For element packets, groups land at consecutive element slots starting at slot zero. When the packet ends, the parser records how many elements the packet described. Downstream fetch logic reads stored entries through two registered read ports.

A header whose length does not fit the group size of its packet type raises a one-cycle error flag, and the whole packet is skipped. Element groups past the storage depth are dropped, and each dropped group raises a one-cycle flag.

Top module: `vip_parser`

## Requirements
- R1: After synchronous reset, the valid bitmap and the element count are zero, and both flags are low.
- R2: A dword with start flag set is a header. Its type code is bits 23:16, with 0x08 for a buffer packet and 0x09 for an element packet. Its length field is bits 7:0, and the body that follows has (field + 1) dwords. A header with any other code causes its body dwords to be consumed with no change to any stored state.
- R3: In a buffer group, dword 0 carries the slot number in bits 31:26 and the pitch in bits 11:0. Dword 3 carries the size. Pitch and size are written for every group.
- R4: Bit 14 of buffer group dword 0 enables an address update. When it is set, the slot address becomes {dword 2, dword 1}. When it is clear, the stored address keeps its old value.
- R5: Each buffer group sets bit <slot> of the valid bitmap, one cycle after its last dword. Bits are cleared only by reset.
- R6: Element group k of a packet is stored at element slot k. Dword 0 gives the source buffer (31:26), valid (25), format (24:16), edge flag (15) and offset (11:0). Dword 1 gives component controls 0..3 in bits 30:28, 26:24, 22:20 and 18:16. These controls read back as ctrl[2:0], ctrl[5:3], ctrl[8:6] and ctrl[11:9].
- R7: The element count changes only on the cycle after the last body dword of a complete element packet. It then becomes (field + 1) / 2, and dropped groups are included in that value.
- R8: A buffer header with (field + 1) not a multiple of 4, or an element header with (field + 1) odd, pulses len_err for one cycle right after the header. Its body changes no stored state.
- R9: An element group whose slot is at or above ELEM_ENTRIES is not stored. elem_drop pulses for one cycle after that group's second dword.
- R10: Both read ports return data one cycle after the index is presented. An element index at or above ELEM_ENTRIES reads as all zero.
- R11: A start flag seen in the middle of a packet abandons that packet and begins a new one. The abandoned element packet does not update the element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Dword present on in_data this cycle |
| in_sop | input | 1 | Dword is a packet header |
| in_data | input | 32 | Command dword |
| len_err | output | 1 | Pulse: header length illegal for its packet type |
| elem_drop | output | 1 | Pulse: element group beyond storage depth |
| buf_valid | output | 64 | Valid bitmap, one bit per buffer slot |
| elem_count | output | 8 | Element count of the last complete element packet |
| buf_rd_idx | input | 6 | Buffer slot to read |
| buf_rd_pitch | output | 12 | Pitch of the slot read |
| buf_rd_addr | output | 64 | Base address of the slot read |
| buf_rd_size | output | 32 | Size of the slot read |
| elem_rd_idx | input | EIW | Element slot to read |
| elem_rd_src | output | 6 | Source buffer of the element |
| elem_rd_vld | output | 1 | Element valid bit |
| elem_rd_fmt | output | 9 | Element format |
| elem_rd_edge | output | 1 | Element edge flag |
| elem_rd_offs | output | 12 | Element offset |
| elem_rd_ctrl | output | 12 | Four 3-bit component controls |

## Verification
The bench builds the parser with ELEM_ENTRIES set to 6 and leaves the buffer codes at their defaults. With only six element slots, a short eight-group element packet is enough to overrun the storage. That packet tests the drop pulses, the count that includes dropped groups, and the zero read above the depth. The buffer side keeps its full 64 slots, so slot 63 is written and read back at the top edge of the bitmap.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int DW        = 32;
  localparam int LEN_W     = 8;
  localparam int BIDX_W    = 6;
  localparam int BUF_SLOTS = 1 << BIDX_W;
  localparam int PITCH_W   = 12;
  localparam int SIZE_W    = 32;
  localparam int ADDR_W    = 64;
  localparam int FMT_W     = 9;
  localparam int OFFS_W    = 12;
  localparam int CC_W      = 3;
  localparam int N_CC      = 4;
  localparam int CTRL_W    = CC_W * N_CC;
  localparam int BODY_W    = LEN_W + 1;

  typedef enum logic [1:0] {PK_IDLE, PK_BUF, PK_ELEM, PK_SKIP} pk_kind_e;

  typedef struct packed {
    logic [BIDX_W-1:0] src;
    logic              vld;
    logic [FMT_W-1:0]  fmt;
    logic              edge_f;
    logic [OFFS_W-1:0] offs;
    logic [CTRL_W-1:0] ctrl;
  } elem_ent_t;
endpackage

// File: rtl/vip_hdr_decode.sv
module vip_hdr_decode
  import vip_pkg::*;
#(
  parameter logic [7:0] BUF_CODE  = 8'h08,
  parameter logic [7:0] ELEM_CODE = 8'h09
) (
  input  logic [7:0]        code,
  input  logic [LEN_W-1:0]  len_field,
  output pk_kind_e          kind,
  output logic              len_bad,
  output logic [BODY_W-1:0] body_len,
  output logic [LEN_W-1:0]  n_groups
);
  always_comb begin
    body_len = {1'b0, len_field} + BODY_W'(1);
    n_groups = body_len[BODY_W-1:1];
    len_bad  = 1'b0;
    kind     = PK_SKIP;
    if (code == BUF_CODE) begin
      len_bad = (body_len[1:0] != 2'b00);
      kind    = len_bad ? PK_SKIP : PK_BUF;
    end else if (code == ELEM_CODE) begin
      len_bad = body_len[0];
      kind    = len_bad ? PK_SKIP : PK_ELEM;
    end
  end
endmodule

// File: rtl/vip_ram.sv
module vip_ram #(
  parameter int W  = 32,
  parameter int D  = 64,
  parameter int AW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vip_parser.sv
module vip_parser
  import vip_pkg::*;
#(
  parameter int         ELEM_ENTRIES = 34,
  parameter logic [7:0] BUF_CODE     = 8'h08,
  parameter logic [7:0] ELEM_CODE    = 8'h09,
  localparam int        EIW          = (ELEM_ENTRIES > 1) ? $clog2(ELEM_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic [DW-1:0]        in_data,
  output logic                 len_err,
  output logic                 elem_drop,
  output logic [BUF_SLOTS-1:0] buf_valid,
  output logic [LEN_W-1:0]     elem_count,
  input  logic [BIDX_W-1:0]    buf_rd_idx,
  output logic [PITCH_W-1:0]   buf_rd_pitch,
  output logic [ADDR_W-1:0]    buf_rd_addr,
  output logic [SIZE_W-1:0]    buf_rd_size,
  input  logic [EIW-1:0]       elem_rd_idx,
  output logic [BIDX_W-1:0]    elem_rd_src,
  output logic                 elem_rd_vld,
  output logic [FMT_W-1:0]     elem_rd_fmt,
  output logic                 elem_rd_edge,
  output logic [OFFS_W-1:0]    elem_rd_offs,
  output logic [CTRL_W-1:0]    elem_rd_ctrl
);
  localparam int PS_W  = PITCH_W + SIZE_W;
  localparam int ENT_W = $bits(elem_ent_t);
  localparam int E0_W  = BIDX_W + 1 + FMT_W + 1 + OFFS_W;

  // header decode
  pk_kind_e          dec_kind;
  logic              dec_bad;
  logic [BODY_W-1:0] dec_body;
  logic [LEN_W-1:0]  dec_groups;

  vip_hdr_decode #(.BUF_CODE(BUF_CODE), .ELEM_CODE(ELEM_CODE)) u_dec (
    .code     (in_data[23:16]),
    .len_field(in_data[LEN_W-1:0]),
    .kind     (dec_kind),
    .len_bad  (dec_bad),
    .body_len (dec_body),
    .n_groups (dec_groups)
  );

  // walk state
  pk_kind_e           kind_q;
  logic [BODY_W-1:0]  remain_q;
  logic [1:0]         phase_q;
  logic [LEN_W-1:0]   eidx_q;
  logic [LEN_W-1:0]   egroups_q;
  logic [BIDX_W-1:0]  bidx_q;
  logic [PITCH_W-1:0] pitch_q;
  logic               mod_q;
  logic [DW-1:0]      alo_q;
  logic [DW-1:0]      ahi_q;
  logic [E0_W-1:0]    e0_q;
  logic               len_err_q, drop_q;
  logic [BUF_SLOTS-1:0] valid_q;
  logic [LEN_W-1:0]   count_q;

  logic hdr_acc, body_acc, last_body;
  logic buf_wr, addr_wr, elem_try, elem_fit, elem_wr;

  assign hdr_acc   = in_valid && in_sop;
  assign body_acc  = in_valid && !in_sop && (kind_q != PK_IDLE);
  assign last_body = body_acc && (remain_q == BODY_W'(1));
  assign buf_wr    = body_acc && (kind_q == PK_BUF) && (phase_q == 2'd3);
  assign addr_wr   = buf_wr && mod_q;
  assign elem_try  = body_acc && (kind_q == PK_ELEM) && phase_q[0];
  assign elem_fit  = ({1'b0, eidx_q} < (LEN_W + 1)'(ELEM_ENTRIES));
  assign elem_wr   = elem_try && elem_fit;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= PK_IDLE;
      remain_q  <= '0;
      phase_q   <= '0;
      eidx_q    <= '0;
      egroups_q <= '0;
      bidx_q    <= '0;
      pitch_q   <= '0;
      mod_q     <= 1'b0;
      alo_q     <= '0;
      ahi_q     <= '0;
      e0_q      <= '0;
      len_err_q <= 1'b0;
      drop_q    <= 1'b0;
      valid_q   <= '0;
      count_q   <= '0;
    end else begin
      len_err_q <= hdr_acc && dec_bad;
      drop_q    <= elem_try && !elem_fit;
      if (hdr_acc) begin
        kind_q    <= dec_kind;
        remain_q  <= dec_body;
        phase_q   <= '0;
        eidx_q    <= '0;
        egroups_q <= dec_groups;
      end else if (body_acc) begin
        remain_q <= remain_q - BODY_W'(1);
        if (last_body) begin
          kind_q <= PK_IDLE;
          if (kind_q == PK_ELEM) count_q <= egroups_q;
        end
        if (kind_q == PK_BUF) begin
          phase_q <= phase_q + 2'd1;
          case (phase_q)
            2'd0: begin
              bidx_q  <= in_data[31:26];
              pitch_q <= in_data[PITCH_W-1:0];
              mod_q   <= in_data[14];
            end
            2'd1: alo_q <= in_data;
            2'd2: ahi_q <= in_data;
            default: valid_q[bidx_q] <= 1'b1;
          endcase
        end else if (kind_q == PK_ELEM) begin
          phase_q <= {1'b0, ~phase_q[0]};
          if (!phase_q[0]) e0_q <= {in_data[31:15], in_data[OFFS_W-1:0]};
          else             eidx_q <= eidx_q + LEN_W'(1);
        end
      end
    end
  end

  // storage: pitch+size always written, address only on request
  logic [PS_W-1:0] ps_rd;

  vip_ram #(.W(PS_W), .D(BUF_SLOTS)) u_ps_ram (
    .clk  (clk),
    .we   (buf_wr),
    .waddr(bidx_q),
    .wdata({pitch_q, in_data}),
    .raddr(buf_rd_idx),
    .rdata(ps_rd)
  );

  vip_ram #(.W(ADDR_W), .D(BUF_SLOTS)) u_addr_ram (
    .clk  (clk),
    .we   (addr_wr),
    .waddr(bidx_q),
    .wdata({ahi_q, alo_q}),
    .raddr(buf_rd_idx),
    .rdata(buf_rd_addr)
  );

  elem_ent_t ent_wr, ent_rd;
  logic [ENT_W-1:0] ent_rd_raw;
  logic elem_oob_q;

  always_comb begin
    ent_wr.src    = e0_q[E0_W-1 -: BIDX_W];
    ent_wr.vld    = e0_q[E0_W-1-BIDX_W];
    ent_wr.fmt    = e0_q[E0_W-2-BIDX_W -: FMT_W];
    ent_wr.edge_f = e0_q[OFFS_W];
    ent_wr.offs   = e0_q[OFFS_W-1:0];
    ent_wr.ctrl   = {in_data[18:16], in_data[22:20], in_data[26:24], in_data[30:28]};
  end

  vip_ram #(.W(ENT_W), .D(ELEM_ENTRIES), .AW(EIW)) u_elem_ram (
    .clk  (clk),
    .we   (elem_wr),
    .waddr(eidx_q[EIW-1:0]),
    .wdata(ent_wr),
    .raddr(elem_rd_idx),
    .rdata(ent_rd_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) elem_oob_q <= 1'b0;
    else     elem_oob_q <= (32'(elem_rd_idx) >= ELEM_ENTRIES);
  end

  assign ent_rd       = elem_oob_q ? '0 : ent_rd_raw;
  assign elem_rd_src  = ent_rd.src;
  assign elem_rd_vld  = ent_rd.vld;
  assign elem_rd_fmt  = ent_rd.fmt;
  assign elem_rd_edge = ent_rd.edge_f;
  assign elem_rd_offs = ent_rd.offs;
  assign elem_rd_ctrl = ent_rd.ctrl;

  assign buf_rd_pitch = ps_rd[PS_W-1 -: PITCH_W];
  assign buf_rd_size  = ps_rd[SIZE_W-1:0];
  assign len_err      = len_err_q;
  assign elem_drop    = drop_q;
  assign buf_valid    = valid_q;
  assign elem_count   = count_q;
endmodule

// File: rtl/vip_parser_chk.sv
module vip_parser_chk
  import vip_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_sop,
  input logic                 len_err,
  input logic                 elem_drop,
  input logic [BUF_SLOTS-1:0] buf_valid,
  input logic [LEN_W-1:0]     elem_count
);
  assert_len_err_after_header_R8: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $past(in_valid && in_sop));

  assert_drop_after_body_R9: assert property (@(posedge clk) disable iff (rst)
    elem_drop |-> $past(in_valid && !in_sop));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({len_err, elem_drop}));

  assert_bitmap_never_clears_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((buf_valid & $past(buf_valid)) == $past(buf_valid)));

  assert_bitmap_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(buf_valid & ~$past(buf_valid)) <= 1));

  assert_bitmap_moves_on_body_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(buf_valid) |-> $past(in_valid && !in_sop));

  assert_count_moves_on_body_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(elem_count) |-> $past(in_valid && !in_sop));
endmodule

bind vip_parser vip_parser_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .len_err   (len_err),
  .elem_drop (elem_drop),
  .buf_valid (buf_valid),
  .elem_count(elem_count)
);

// File: tb/vip_parser_test.sv
module vip_parser_test;
  localparam int NE  = 6;
  localparam int EIW = $clog2(NE);
  localparam int NV  = 36;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic        len_err, elem_drop;
  logic [63:0] buf_valid;
  logic [7:0]  elem_count;
  logic [5:0]  buf_rd_idx = '0;
  logic [11:0] buf_rd_pitch;
  logic [63:0] buf_rd_addr;
  logic [31:0] buf_rd_size;
  logic [EIW-1:0] elem_rd_idx = '0;
  logic [5:0]  elem_rd_src;
  logic        elem_rd_vld, elem_rd_edge;
  logic [8:0]  elem_rd_fmt;
  logic [11:0] elem_rd_offs, elem_rd_ctrl;

  int n_chk = 0, n_bad = 0, drops = 0;

  always #2.5 clk = ~clk;

  vip_parser #(.ELEM_ENTRIES(NE)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .len_err(len_err), .elem_drop(elem_drop), .buf_valid(buf_valid), .elem_count(elem_count),
    .buf_rd_idx(buf_rd_idx), .buf_rd_pitch(buf_rd_pitch), .buf_rd_addr(buf_rd_addr),
    .buf_rd_size(buf_rd_size), .elem_rd_idx(elem_rd_idx), .elem_rd_src(elem_rd_src),
    .elem_rd_vld(elem_rd_vld), .elem_rd_fmt(elem_rd_fmt), .elem_rd_edge(elem_rd_edge),
    .elem_rd_offs(elem_rd_offs), .elem_rd_ctrl(elem_rd_ctrl)
  );

  // {sop, expected len_err after this dword, data}
  localparam logic [33:0] STIM [NV] = '{
    {2'b10, 32'h0008_0007}, {2'b00, 32'h1400_4123}, {2'b00, 32'hAAAA_0001},
    {2'b00, 32'h0000_BEEF}, {2'b00, 32'h0000_1000}, {2'b00, 32'hFC00_4FFF},
    {2'b00, 32'h1111_2222}, {2'b00, 32'h3333_4444}, {2'b00, 32'h0000_0800},
    {2'b10, 32'h0008_0003}, {2'b00, 32'h1400_0045}, {2'b00, 32'hDEAD_DEAD},
    {2'b00, 32'hDEAD_DEAD}, {2'b00, 32'h0000_2000},
    {2'b10, 32'h0009_0005}, {2'b00, 32'h17AB_8010}, {2'b00, 32'h1234_FFFF},
    {2'b00, 32'hFC00_0FFF}, {2'b00, 32'h7777_0000}, {2'b00, 32'h0000_0001},
    {2'b00, 32'h0000_0000},
    {2'b11, 32'h0008_0004}, {2'b00, 32'h1C00_4111}, {2'b00, 32'h0000_0001},
    {2'b00, 32'h0000_0002}, {2'b00, 32'h0000_0003}, {2'b00, 32'h0000_0004},
    {2'b11, 32'h0009_0002}, {2'b00, 32'hFFFF_FFFF}, {2'b00, 32'hFFFF_FFFF},
    {2'b00, 32'hFFFF_FFFF},
    {2'b10, 32'h0042_0003}, {2'b00, 32'h2400_4222}, {2'b00, 32'h0000_0005},
    {2'b00, 32'h0000_0006}, {2'b00, 32'h0000_0007}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic sop, input logic [31:0] d);
    in_valid = 1'b1; in_sop = sop; in_data = d;
    @(posedge clk); #1;
    if (elem_drop) drops++;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
    @(posedge clk); #1;
  endtask

  task automatic rd_buf(input logic [5:0] i);
    buf_rd_idx = i; @(posedge clk); #1;
  endtask

  task automatic rd_elem(input logic [EIW-1:0] i);
    elem_rd_idx = i; @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1 bitmap", 64'(buf_valid), 64'd0);
    check("R1 count", 64'(elem_count), 64'd0);
    check("R1 flags", 64'({len_err, elem_drop}), 64'd0);

    // table walk; len_err checked after every dword (R8, R2)
    for (int i = 0; i < NV; i++) begin
      send(STIM[i][33], STIM[i][31:0]);
      check("R8 len_err pulse", 64'(len_err), 64'(STIM[i][32]));
    end
    idle();

    check("R5 bitmap (R2 skip, R8 discard)", buf_valid, (64'd1 << 5) | (64'd1 << 63));
    check("R7 count after bad packet", 64'(elem_count), 64'd3);

    rd_buf(6'd5);
    check("R3 pitch slot5", 64'(buf_rd_pitch), 64'h045);
    check("R4 addr kept slot5", buf_rd_addr, 64'h0000BEEF_AAAA0001);
    check("R3 size slot5", 64'(buf_rd_size), 64'h2000);
    rd_buf(6'd63);
    check("R3 pitch slot63", 64'(buf_rd_pitch), 64'hFFF);
    check("R4 addr slot63", buf_rd_addr, 64'h33334444_11112222);
    check("R3 size slot63", 64'(buf_rd_size), 64'h800);

    rd_elem(3'd0);
    check("R6 elem0 fields", 64'({elem_rd_src, elem_rd_vld, elem_rd_fmt, elem_rd_edge, elem_rd_offs}),
          64'({6'd5, 1'b1, 9'h1AB, 1'b1, 12'h010}));
    check("R6 elem0 ctrl", 64'(elem_rd_ctrl), 64'h8D1);
    rd_elem(3'd1);
    check("R6 elem1 fields", 64'({elem_rd_src, elem_rd_vld, elem_rd_fmt, elem_rd_edge, elem_rd_offs}),
          64'({6'd63, 1'b0, 9'h0, 1'b0, 12'hFFF}));
    check("R6 elem1 ctrl", 64'(elem_rd_ctrl), 64'hFFF);
    rd_elem(3'd2);
    check("R6 elem2 offs", 64'(elem_rd_offs), 64'h001);
    rd_elem(3'd7);
    check("R10 oob read zero", 64'({elem_rd_src, elem_rd_vld, elem_rd_fmt, elem_rd_edge,
          elem_rd_offs, elem_rd_ctrl}), 64'd0);

    // overflow: 8 groups into 6 slots (R9, R7)
    drops = 0;
    send(1'b1, 32'h0009_000F);
    for (int g = 0; g < 8; g++) begin
      send(1'b0, (32'(g) << 26) | 32'(g));
      if (g == 7) check("R7 count before last dword", 64'(elem_count), 64'd3);
      send(1'b0, 32'h0);
    end
    check("R7 count incl dropped", 64'(elem_count), 64'd8);
    idle();
    check("R9 drop pulses", 64'(drops), 64'd2);
    rd_elem(3'd5);
    check("R9 last stored slot", 64'({elem_rd_src, elem_rd_offs}), 64'({6'd5, 12'd5}));
    rd_elem(3'd0);
    check("R6 restart at slot0", 64'({elem_rd_src, elem_rd_offs}), 64'd0);

    // truncated element packet, new buffer packet (R11)
    send(1'b1, 32'h0009_0003);
    send(1'b0, 32'h0000_0009);
    send(1'b0, 32'h0);
    send(1'b1, 32'h0008_0003);
    send(1'b0, 32'h0800_4007);
    send(1'b0, 32'h0000_0077);
    send(1'b0, 32'h0000_0066);
    send(1'b0, 32'h0000_0055);
    idle();
    check("R11 count untouched", 64'(elem_count), 64'd8);
    check("R11 new packet bit2", 64'(buf_valid[2]), 64'd1);
    rd_buf(6'd2);
    check("R11 new packet addr", buf_rd_addr, 64'h00000066_00000077);

    // reset again (R1)
    rst = 1'b1; @(posedge clk); @(posedge clk); #1; rst = 1'b0;
    check("R1 bitmap after reset", buf_valid, 64'd0);
    check("R1 count after reset", 64'(elem_count), 64'd0);
    finish_run();
  end
endmodule